// File: doc/BRIEF.md
# Facility data link receive capture

This block collects the serial bits of a facility data link, one bit per strobe, into bytes. Bits arrive least significant first on `bit_i`, qualified by `bit_valid_i`. Once eight bits have been accepted, the block copies the completed byte into a holding register and raises a sticky buffer-full flag. The host then has one whole byte period to read the byte before the next one replaces it.

Each completed byte is compared with two match bytes that the host programs. Equality with either byte raises a sticky match flag. A host can therefore leave the link alone until a byte it cares about shows up. Each flag has its own mask bit. Any flag that is set while its mask bit is set pulls the active-low interrupt output low.

A switchable zero destuffer can be placed in front of the shift register. When it is enabled, a 0 that follows five consecutive 1s is dropped. That dropped 0 is not shifted in and is not counted toward the byte.

Top module: `fdl_rx_capture`

## Requirements
- R1: Bits are accepted only on cycles where `bit_valid_i` is 1. The first accepted bit of a byte lands in bit 0 of `byte_o` and the eighth lands in bit 7. `byte_o` takes the new byte on the clock edge that accepts the eighth bit.
- R2: `full_flag_o` becomes 1 on the clock edge that completes a byte.
- R3: `byte_o` holds its value until the next byte completes. A change on `bit_i` while `bit_valid_i` is 0 has no effect on `byte_o`, on `full_flag_o` or on the bit count.
- R4: `match_flag_o` becomes 1 on the completing edge when the new byte equals `match_a_i` or `match_b_i`. It stays 0 when the byte equals neither.
- R5: Both flags are sticky. A 1 on `clr_full_i` clears `full_flag_o` at the next edge, and a 1 on `clr_match_i` clears `match_flag_o` at the next edge. Each clear affects only its own flag. If a byte completes on the same edge as a clear, the set wins.
- R6: `irq_no` is 0 exactly when (`full_flag_o` and `full_mask_i`) or (`match_flag_o` and `match_mask_i`) holds. Otherwise it is 1.
- R7: With `destuff_en_i` at 1, a 0 that arrives after five consecutive accepted 1s is discarded. It does not advance the bit count.
- R8: With `destuff_en_i` at 0, every valid bit is shifted in, including a 0 that follows five 1s.
- R9: Reset (`rst_ni` low) clears `byte_o`, both flags and the partial bit count. `irq_no` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data link bit |
| bit_valid_i | input | 1 | Qualifies `bit_i` for one cycle |
| destuff_en_i | input | 1 | Enables the zero destuffer |
| match_a_i | input | 8 | First match byte |
| match_b_i | input | 8 | Second match byte |
| full_mask_i | input | 1 | Lets the buffer-full flag drive the interrupt |
| match_mask_i | input | 1 | Lets the match flag drive the interrupt |
| clr_full_i | input | 1 | Clears the buffer-full flag |
| clr_match_i | input | 1 | Clears the match flag |
| byte_o | output | 8 | Last completed byte |
| full_flag_o | output | 1 | Sticky buffer-full flag |
| match_flag_o | output | 1 | Sticky match flag |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench tries byte capture with several kinds of byte:
- bytes that match only the first match byte;
- bytes that match only the second match byte;
- bytes that match both match bytes;
- bytes one bit away from a match byte.

Together these separate a correct dual compare from an OR of the wrong operands or a compare against a single byte. The 1,1,1,1,1,0 run is sent once with destuffing off and once with it on. Because the resulting bytes differ, a drop decision at the wrong run length, or a dropped bit that still advances the count, shows up in the byte value. Gaps in `bit_valid_i` while `bit_i` toggles, together with a reset in the middle of a byte, show whether bits are counted only when strobed.

// File: rtl/fdl_rx_pkg.sv
package fdl_rx_pkg;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned RUN_MAX = 5;
  parameter int unsigned NUM_PAT = 2;
endpackage

// File: rtl/fdl_destuff.sv
module fdl_destuff #(
  parameter int unsigned RUN_MAX = fdl_rx_pkg::RUN_MAX
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic accept_o
);
  localparam int unsigned RUN_W = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_MAX);

  logic [RUN_W-1:0] run_q;
  logic             drop;

  // stuffed zero: the first 0 after a full run of ones
  assign drop     = en_i && (run_q == RUN_LIM) && !bit_i;
  assign accept_o = valid_i && !drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!en_i) begin
      run_q <= '0;
    end else if (valid_i) begin
      if (!bit_i)                run_q <= '0;
      else if (run_q != RUN_LIM) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/fdl_shift_acc.sv
module fdl_shift_acc #(
  parameter int unsigned BYTE_W = fdl_rx_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  // lsb first: new bit enters at the top and moves down
  assign byte_o = {bit_i, sr_q[BYTE_W-1:1]};
  assign done_o = shift_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fdl_byte_match.sv
module fdl_byte_match #(
  parameter int unsigned BYTE_W  = fdl_rx_pkg::BYTE_W,
  parameter int unsigned NUM_PAT = fdl_rx_pkg::NUM_PAT
) (
  input  logic [BYTE_W-1:0]              byte_i,
  input  logic [NUM_PAT-1:0][BYTE_W-1:0] pat_i,
  output logic                           hit_o
);
  logic [NUM_PAT-1:0] eq;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_cmp
    assign eq[g] = (byte_i == pat_i[g]);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/fdl_rx_capture.sv
module fdl_rx_capture #(
  parameter int unsigned BYTE_W  = fdl_rx_pkg::BYTE_W,
  parameter int unsigned RUN_MAX = fdl_rx_pkg::RUN_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              destuff_en_i,
  input  logic [BYTE_W-1:0] match_a_i,
  input  logic [BYTE_W-1:0] match_b_i,
  input  logic              full_mask_i,
  input  logic              match_mask_i,
  input  logic              clr_full_i,
  input  logic              clr_match_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              full_flag_o,
  output logic              match_flag_o,
  output logic              irq_no
);
  localparam int unsigned NUM_PAT = 2;

  logic                           bit_accept;
  logic                           byte_done;
  logic [BYTE_W-1:0]              byte_new;
  logic                           hit;
  logic [NUM_PAT-1:0][BYTE_W-1:0] pats;
  logic [BYTE_W-1:0]              hold_q;
  logic                           full_q;
  logic                           match_q;

  assign pats = {match_b_i, match_a_i};

  fdl_destuff #(.RUN_MAX(RUN_MAX)) u_destuff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (destuff_en_i),
    .valid_i (bit_valid_i),
    .bit_i   (bit_i),
    .accept_o(bit_accept)
  );

  fdl_shift_acc #(.BYTE_W(BYTE_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(bit_accept),
    .bit_i  (bit_i),
    .done_o (byte_done),
    .byte_o (byte_new)
  );

  fdl_byte_match #(.BYTE_W(BYTE_W), .NUM_PAT(NUM_PAT)) u_match (
    .byte_i(byte_new),
    .pat_i (pats),
    .hit_o (hit)
  );

  // set beats clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (byte_done) hold_q <= byte_new;

      if (byte_done)       full_q <= 1'b1;
      else if (clr_full_i) full_q <= 1'b0;

      if (byte_done && hit) match_q <= 1'b1;
      else if (clr_match_i) match_q <= 1'b0;
    end
  end

  assign byte_o       = hold_q;
  assign full_flag_o  = full_q;
  assign match_flag_o = match_q;
  assign irq_no       = !((full_q && full_mask_i) || (match_q && match_mask_i));
endmodule

// File: rtl/fdl_rx_capture_chk.sv
module fdl_rx_capture_chk #(
  parameter int unsigned BYTE_W  = fdl_rx_pkg::BYTE_W,
  parameter int unsigned RUN_MAX = fdl_rx_pkg::RUN_MAX
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_i,
  input logic              bit_valid_i,
  input logic              destuff_en_i,
  input logic [BYTE_W-1:0] match_a_i,
  input logic [BYTE_W-1:0] match_b_i,
  input logic              full_mask_i,
  input logic              match_mask_i,
  input logic              clr_full_i,
  input logic              clr_match_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic              full_flag_o,
  input logic              match_flag_o,
  input logic              irq_no,
  input logic              accept_i
);
  localparam int unsigned RUN_W = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_MAX);

  // independent count of accepted ones seen on the wire
  logic [RUN_W-1:0] ones_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ones_q <= '0;
    else if (!destuff_en_i)             ones_q <= '0;
    else if (bit_valid_i && !bit_i)     ones_q <= '0;
    else if (bit_valid_i && ones_q != RUN_LIM) ones_q <= ones_q + 1'b1;
  end

  assert_irq_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_mask_i && !match_mask_i) |-> irq_no);

  assert_full_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_flag_o && !clr_full_i) |=> full_flag_o);

  assert_match_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !clr_match_i) |=> match_flag_o);

  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(byte_o) |-> full_flag_o);

  assert_match_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_flag_o) |-> (byte_o == $past(match_a_i) || byte_o == $past(match_b_i)));

  assert_stuff_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (destuff_en_i && ones_q == RUN_LIM && bit_valid_i && !bit_i) |-> !accept_i);

  assert_no_idle_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |-> !accept_i);
endmodule

bind fdl_rx_capture fdl_rx_capture_chk #(.BYTE_W(BYTE_W), .RUN_MAX(RUN_MAX)) u_chk (
  .clk_i, .rst_ni, .bit_i, .bit_valid_i, .destuff_en_i, .match_a_i, .match_b_i,
  .full_mask_i, .match_mask_i, .clr_full_i, .clr_match_i, .byte_o, .full_flag_o,
  .match_flag_o, .irq_no, .accept_i(bit_accept)
);

// File: tb/fdl_rx_capture_tb_top.sv
module fdl_rx_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0, bit_valid_i = 1'b0, destuff_en_i = 1'b0;
  logic [7:0] match_a_i = 8'h00, match_b_i = 8'h00;
  logic       full_mask_i = 1'b0, match_mask_i = 1'b0;
  logic       clr_full_i = 1'b0, clr_match_i = 1'b0;
  logic [7:0] byte_o;
  logic       full_flag_o, match_flag_o, irq_no;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  fdl_rx_capture dut_i (
    .clk_i(clk), .rst_ni, .bit_i, .bit_valid_i, .destuff_en_i, .match_a_i, .match_b_i,
    .full_mask_i, .match_mask_i, .clr_full_i, .clr_match_i, .byte_o, .full_flag_o,
    .match_flag_o, .irq_no
  );

  // {data, match_a, match_b, expected match}
  localparam logic [24:0] VEC [6] = '{
    {8'hA5, 8'hA5, 8'h00, 1'b1},
    {8'h3C, 8'h00, 8'h3C, 1'b1},
    {8'hFF, 8'hFE, 8'h7F, 1'b0},
    {8'h00, 8'h01, 8'h80, 1'b0},
    {8'h81, 8'h81, 8'h81, 1'b1},
    {8'h5A, 8'hA5, 8'h5B, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_i = b; bit_valid_i = 1'b1;
    @(negedge clk);
    bit_valid_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_full_i = 1'b1; clr_match_i = 1'b1;
    @(negedge clk);
    clr_full_i = 1'b0; clr_match_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 byte after reset", byte_o, 8'h00);
    check("R9 full after reset", {7'd0, full_flag_o}, 8'd0);
    check("R9 irq after reset", {7'd0, irq_no}, 8'd1);
    rst_ni = 1'b1;

    // vector table: R1 R2 R4
    foreach (VEC[k]) begin
      match_a_i = VEC[k][16:9]; match_b_i = VEC[k][8:1];
      clear_flags();
      send_byte(VEC[k][24:17]);
      check("R1 byte value", byte_o, VEC[k][24:17]);
      check("R2 full set", {7'd0, full_flag_o}, 8'd1);
      check("R4 match flag", {7'd0, match_flag_o}, {7'd0, VEC[k][0]});
    end

    // R3: idle toggling and partial byte leave outputs untouched
    match_a_i = 8'h11; match_b_i = 8'h22;
    clear_flags();
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_i = ~bit_i;
    end
    check("R3 byte held", byte_o, 8'h5A);
    check("R3 no full on 7 bits", {7'd0, full_flag_o}, 8'd0);
    send_bit(1'b1);
    check("R3 idle bits not counted", byte_o, 8'h80);

    // R5 sticky and clears
    repeat (4) @(negedge clk);
    check("R5 full sticky", {7'd0, full_flag_o}, 8'd1);
    match_a_i = 8'h80;
    clear_flags();
    send_byte(8'h80);
    @(negedge clk); clr_full_i = 1'b1;
    @(negedge clk); clr_full_i = 1'b0;
    check("R5 full cleared", {7'd0, full_flag_o}, 8'd0);
    check("R5 match kept", {7'd0, match_flag_o}, 8'd1);

    // R6 interrupt masking
    check("R6 irq masked", {7'd0, irq_no}, 8'd1);
    @(negedge clk); full_mask_i = 1'b1;
    #1 check("R6 full mask no effect when clear", {7'd0, irq_no}, 8'd1);
    @(negedge clk); match_mask_i = 1'b1;
    #1 check("R6 match irq", {7'd0, irq_no}, 8'd0);
    @(negedge clk); match_mask_i = 1'b0;
    clr_match_i = 1'b1;
    @(negedge clk); clr_match_i = 1'b0;

    // R5 set wins over clear on the completing edge
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    @(negedge clk); bit_i = 1'b1; bit_valid_i = 1'b1; clr_full_i = 1'b1;
    @(negedge clk); bit_valid_i = 1'b0; clr_full_i = 1'b0;
    check("R5 set beats clear", {7'd0, full_flag_o}, 8'd1);
    check("R6 full irq", {7'd0, irq_no}, 8'd0);
    full_mask_i = 1'b0;

    // R8 destuff off: stuffed-looking zero is kept
    destuff_en_i = 1'b0;
    clear_flags();
    send_bit(1); send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    send_bit(0); send_bit(1); send_bit(1);
    check("R8 zero kept", byte_o, 8'hDF);

    // R7 destuff on: zero after five ones dropped, not counted
    destuff_en_i = 1'b1;
    clear_flags();
    send_bit(1); send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    send_bit(0); send_bit(1); send_bit(1);
    check("R7 dropped zero not counted", {7'd0, full_flag_o}, 8'd0);
    send_bit(1);
    check("R7 destuffed byte", byte_o, 8'hFF);
    destuff_en_i = 1'b0;

    // R9 reset mid-byte discards partial bits
    send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R9 flags cleared", {6'd0, full_flag_o, match_flag_o}, 8'd0);
    rst_ni = 1'b1;
    send_byte(8'hA5);
    check("R9 partial count cleared", byte_o, 8'hA5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule